// File: doc/BRIEF.md
# Glitch-free two-clock switch

This block routes one of two free-running clocks onto a single output clock. The select input may toggle at any moment, with no timing relation to either clock. A change of select never produces a shortened high or low phase on the output. The cost is that the output can show one stretched phase while the handover takes place.

Each source clock has its own gating leg, built only from flip-flops clocked by that source. The leg that currently drives the output closes its gate first, in step with its own clock. The other leg sees that closure through a synchroniser and only then opens its gate, in step with its own clock. Gates update on the falling edge of their clock and are combined with AND and OR logic. The output therefore rests low while neither gate is open. A status output reports whether the second clock is the one currently gated through.

The gating adds delay between each source and the output. Both source clocks must keep running for a switch to finish.

Top module: `glitchfree_clk_switch`

## Requirements
- R1: While reset is low and after it is released with `sel_b` = 0, `clk_out` follows `clk_a` and `on_b` is 0.
- R2: At no instant are both gates open; at most one source clock reaches `clk_out`.
- R3: Every high phase and every low phase of `clk_out` lasts at least the shorter of the two source half-periods, across any number of select changes.
- R4: Encoding: `sel_b` = 1 selects `clk_b` and `sel_b` = 0 selects `clk_a`. Once `sel_b` has been steady for SYNC_STAGES+2 cycles of each clock, `on_b` equals `sel_b` and `clk_out` runs at the selected clock's period.
- R5: `sel_b` may change at any time, unrelated to either clock, and R3 still holds.
- R6: A gate opens only while the other gate is closed. A closed gate stays closed for as long as the other gate is open.
- R7: If the outgoing clock is stopped while low, a requested switch does not complete: `on_b` keeps its value and `clk_out` has no edge. When that clock restarts, the switch completes.
- R8: A gate closes only after its source has been deselected by `sel_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | First source clock, selected after reset |
| clk_b | input | 1 | Second source clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised in each clock domain |
| sel_b | input | 1 | Asynchronous select: 1 requests `clk_b`, 0 requests `clk_a` |
| clk_out | output | 1 | Switched output clock |
| on_b | output | 1 | 1 while the `clk_b` gate is open |

## Verification
The assertions assume that `sel_b` stays steady long enough for a started handover to finish. Both legs must have settled before the select moves again. Otherwise one leg may still be opening on a stale request while the other is asked to open.

The assertions also assume that both source clocks run, apart from the deliberate pause in which the outgoing clock is held low. The stimulus changes `sel_b` at random sub-nanosecond offsets relative to either clock. It always waits at least 150 ns between changes, far longer than a handover needs, and it pauses `clk_a` only at a low level.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  // default depth of the cross-domain request synchroniser
  localparam int unsigned SYNC_DEFAULT     = 2;
  // default depth of each per-domain reset release synchroniser
  localparam int unsigned RST_SYNC_DEFAULT = 2;
  // number of source clocks and their leg indices
  localparam int unsigned NUM_SRC = 2;
  localparam int unsigned SRC_A   = 0;
  localparam int unsigned SRC_B   = 1;
endpackage

// File: rtl/clksw_rst_sync.sv
module clksw_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= {STAGES{RST_VAL}};
    end else begin
      sync_q <= sync_d;
    end
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/clksw_leg.sv
module clksw_leg #(
  parameter int unsigned STAGES      = 2,
  parameter int unsigned RST_STAGES  = 2,
  parameter bit          ON_AT_RESET = 1'b0
) (
  input  logic clk_i,
  input  logic arst_ni,
  input  logic want_i,
  input  logic other_en_i,
  output logic en_o
);
  logic rst_n_sync;
  logic req;
  logic req_sync;
  logic en_q;
  logic en_d;
  logic en_load;

  clksw_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_n_sync)
  );

  // ask for the gate only while the other leg reports its gate closed
  assign req = want_i & ~other_en_i;

  clksw_sync #(.STAGES(STAGES), .RST_VAL(ON_AT_RESET)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_sync),
    .d_i   (req),
    .q_o   (req_sync)
  );

  always_comb begin
    en_d    = req_sync;
    en_load = (en_d != en_q);
  end

  // gate flop moves on the falling edge, so it only changes while clk_i is low
  always_ff @(negedge clk_i or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      en_q <= ON_AT_RESET;
    end else if (en_load) begin
      en_q <= en_d;
    end
  end

  assign en_o = en_q;

  // R6
  open_after_close_chk: assert property (@(negedge clk_i) disable iff (!rst_n_sync)
    $rose(en_q) |-> !other_en_i);

  // R6
  stay_closed_chk: assert property (@(negedge clk_i) disable iff (!rst_n_sync)
    (other_en_i && !en_q) |=> !en_q);

  // R8
  close_on_deselect_chk: assert property (@(negedge clk_i) disable iff (!rst_n_sync)
    $fell(en_q) |-> !$past(want_i));
endmodule

// File: rtl/glitchfree_clk_switch.sv
module glitchfree_clk_switch
  import clksw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SYNC_DEFAULT,
  parameter int unsigned RST_STAGES  = RST_SYNC_DEFAULT
) (
  input  logic clk_a,
  input  logic clk_b,
  input  logic rst_n,
  input  logic sel_b,
  output logic clk_out,
  output logic on_b
);
  logic [NUM_SRC-1:0] clk_src;
  logic [NUM_SRC-1:0] want;
  logic [NUM_SRC-1:0] en;
  logic [NUM_SRC-1:0] gated;

  assign clk_src = {clk_b, clk_a};
  assign want    = {sel_b, ~sel_b};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leg
    clksw_leg #(
      .STAGES     (SYNC_STAGES),
      .RST_STAGES (RST_STAGES),
      .ON_AT_RESET(i == SRC_A)
    ) u_leg (
      .clk_i     (clk_src[i]),
      .arst_ni   (rst_n),
      .want_i    (want[i]),
      .other_en_i(en[NUM_SRC-1-i]),
      .en_o      (en[i])
    );
    assign gated[i] = clk_src[i] & en[i];
  end

  assign clk_out = |gated;
  assign on_b    = en[SRC_B];

  // R2
  always_comb begin
    if (rst_n) begin
      onehot_en_chk: assert (!(en[SRC_A] && en[SRC_B]));
    end
  end
endmodule

// File: tb/tb_glitchfree_clk_switch.sv
`timescale 1ns/10ps
module tb_glitchfree_clk_switch;
  localparam real HALF_A  = 5.0;
  localparam real HALF_B  = 3.3;
  localparam real MIN_PH  = 3.3;
  localparam real TOL     = 0.05;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic a_run = 1'b1;
  logic rst_n;
  logic sel_b;
  logic clk_out;
  logic on_b;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  // monitor state
  bit  mon_on   = 0;
  bit  have_edge = 0;
  real last_t   = 0.0;
  real min_ph   = 1.0e9;
  int  runt_cnt = 0;
  int  edge_cnt = 0;

  always #5 clk_a = a_run ? ~clk_a : 1'b0;
  always #3.3 clk_b = ~clk_b;

  glitchfree_clk_switch dut (
    .clk_a  (clk_a),
    .clk_b  (clk_b),
    .rst_n  (rst_n),
    .sel_b  (sel_b),
    .clk_out(clk_out),
    .on_b   (on_b)
  );

  always @(posedge clk_out or negedge clk_out) begin
    edge_cnt++;
    if (mon_on) begin
      if (have_edge) begin
        if ($realtime - last_t < min_ph) min_ph = $realtime - last_t;
        if ($realtime - last_t < MIN_PH - TOL) runt_cnt++;
      end
      have_edge = 1;
      last_t = $realtime;
    end
  end

  function automatic real exp_period(input bit use_b);
    return use_b ? 2.0 * HALF_B : 2.0 * HALF_A;
  endfunction

  task automatic check(input string tag, input bit ok, input string detail);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s", tag, detail);
    end
  endtask

  task automatic check_period(input string tag, input bit use_b);
    real t0, t1, want_p;
    want_p = exp_period(use_b);
    @(posedge clk_out); t0 = $realtime;
    @(posedge clk_out); t1 = $realtime;
    check(tag, ((t1 - t0) > want_p - TOL) && ((t1 - t0) < want_p + TOL),
          $sformatf("period got %0.2f expected %0.2f", t1 - t0, want_p));
  endtask

  task automatic check_settled(input string tag, input bit exp_b, input int runt_before);
    check(tag, on_b == exp_b, $sformatf("on_b got %0d expected %0d", on_b, exp_b));
    check_period(tag, exp_b);
    check("R3", runt_cnt == runt_before,
          $sformatf("runt phases got %0d expected 0 (min %0.2f)", runt_cnt - runt_before, min_ph));
  endtask

  initial begin
    int rb;
    int ec;
    void'($urandom(32'd20050812));
    rst_n = 1'b0;
    sel_b = 1'b0;
    #40;
    // R1 during reset
    check("R1", on_b == 1'b0, $sformatf("on_b in reset got %0d expected 0", on_b));
    check_period("R1", 1'b0);
    #3.27 rst_n = 1'b1;
    #100;
    mon_on = 1;
    rb = runt_cnt;
    #50;
    check_settled("R1", 1'b0, rb);

    // R4 directed switches both ways
    rb = runt_cnt;
    #1.13 sel_b = 1'b1;
    #200;
    check_settled("R4", 1'b1, rb);
    rb = runt_cnt;
    #0.71 sel_b = 1'b0;
    #200;
    check_settled("R4", 1'b0, rb);

    // R5 random asynchronous select changes
    for (int n = 0; n < 40; n++) begin
      bit nv;
      #(real'($urandom_range(150, 400)) + real'($urandom_range(0, 99)) * 0.01);
      nv = (n % 4 == 3) ? sel_b : ~sel_b;
      rb = runt_cnt;
      sel_b = nv;
      #200;
      check_settled("R5", nv, rb);
    end

    // R7 stall while outgoing clock is paused low
    sel_b = 1'b0;
    #200;
    a_run = 1'b0;
    #20;
    ec = edge_cnt;
    rb = runt_cnt;
    #0.37 sel_b = 1'b1;
    #300;
    check("R7", on_b == 1'b0, $sformatf("on_b while stalled got %0d expected 0", on_b));
    check("R7", edge_cnt == ec, $sformatf("clk_out edges while stalled got %0d expected 0", edge_cnt - ec));
    a_run = 1'b1;
    #200;
    check_settled("R7", 1'b1, rb);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired got running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule